// File: doc/BRIEF.md
# Interrupt Cause Register Group

This block collects interrupt causes for one event group, such as transmit completions, receive completions or miscellaneous firmware events. Each hardware event pulse on `evt_i` sets a sticky cause bit. The bit stays set until software clears it. A mask register decides which cause bits may drive the group interrupt line `irq_o`. Software masks bits through one write-only address and unmasks them through another. The current mask can be read from a third address.

A clear-mode register picks, bit by bit, how a cause bit is acknowledged. In read-clears mode the bit drops when the cause register is read. In one-writes-clear mode the bit drops only when a one is written to it, so writing back the value just read acknowledges exactly what was seen. A second read address shows the unmasked pending causes and has no side effects. The register port is a plain single-cycle port. It has one address for both reads and writes, and read data is registered.

Top module: `irq_cause_group`

Address map (3-bit `addr`):
- 0: cause, read/write.
- 1: pending view, read-only.
- 2: mask-set, write-only.
- 3: mask-clear, write-only.
- 4: mask value, read-only.
- 5: clear mode, read/write.

## Requirements
- R1: After a synchronous reset, the following hold: all cause bits are 0, the clear-mode register is 0, every mask bit is 1, `irq_o` is 0 and `rdata` is 0.
- R2: A 1 on `evt_i[i]` in a cycle sets cause bit i at that clock edge. The bit then stays 1 until it is cleared by software.
- R3: A write to address 2 sets to 1 every mask bit whose `wdata` bit is 1 and leaves the other mask bits unchanged.
- R4: A write to address 3 clears to 0 every mask bit whose `wdata` bit is 1 and leaves the other mask bits unchanged.
- R5: A read of address 4 returns the current mask. A write to address 4 has no effect on the mask.
- R6: Address 5 holds the clear mode and reads back what was written. A 1 in bit i selects read-clears for cause bit i. A 0 selects one-writes-clear.
- R7: A write to address 0 clears each cause bit whose `wdata` bit is 1 and whose clear-mode bit is 0. Cause bits in read-clears mode ignore the write.
- R8: A read of address 0 returns the cause bits and clears those whose clear-mode bit is 1. Bits in one-writes-clear mode are not changed by the read.
- R9: A read of address 1 returns cause AND NOT mask and clears no cause bit.
- R10: An event arriving in the same cycle as a read clear or a write clear of the same bit wins, and the bit stays 1.
- R11: `irq_o` is registered. At every edge it becomes the OR over all bits of (new cause AND NOT new mask). It therefore follows a mask or clear action at the same edge that updates the registers.
- R12: `rdata` is registered and holds, one edge after a cycle with `rd_en`, the value read from `addr`. It is 0 for addresses 2, 3, 6 and 7 and in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | W | Event pulses, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data |
| irq_o | output | 1 | Registered group interrupt |

## Verification
The cause path is tried with single-bit events, with multi-bit event words and with events that collide with a clear on the same bit. The collision case tells a design where the event wins apart from one that loses events. Both clear modes are applied to neighbouring bits of the same word. This shows whether reads and writes touch only the bits of the right mode. Mask-set and mask-clear are applied with sparse words and with all-ones words, and `irq_o` is watched each time. A write to the read-only mask address and reads of the side-effect-free view confirm that those accesses leave state alone. A reference model compares `rdata` and `irq_o` on every cycle.

// File: rtl/icg_pkg.sv
package icg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CAUSE   = 3'd0,
    A_PENDING = 3'd1,
    A_MSET    = 3'd2,
    A_MCLR    = 3'd3,
    A_MASK    = 3'd4,
    A_MODE    = 3'd5
  } icg_addr_e;

  typedef struct packed {
    logic cause_rd;
    logic cause_wr;
    logic mset_wr;
    logic mclr_wr;
    logic mode_wr;
  } icg_strobe_t;
endpackage

// File: rtl/icg_decode.sv
module icg_decode
  import icg_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output icg_strobe_t       strb
);
  always_comb begin
    strb          = '0;
    strb.cause_rd = rd_en && (addr == A_CAUSE);
    strb.cause_wr = wr_en && (addr == A_CAUSE);
    strb.mset_wr  = wr_en && (addr == A_MSET);
    strb.mclr_wr  = wr_en && (addr == A_MCLR);
    strb.mode_wr  = wr_en && (addr == A_MODE);
  end
endmodule

// File: rtl/icg_mask_reg.sv
module icg_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] ALL_MASKED = '1;

  always_comb begin
    mask_d = mask_q;
    if (set_wr) mask_d = mask_d | wdata;
    if (clr_wr) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= ALL_MASKED;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/icg_cause_reg.sv
module icg_cause_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic         mode_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_d,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wdata;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_i;
    // read clear applies to read-clears bits, write clear to the others
    assign clr_i      = mode_q[i] ? rd_hit : (wr_hit && wdata[i]);
    // an event in the same cycle overrides any clear
    assign cause_d[i] = evt_i[i] | (cause_q[i] & ~clr_i);

    always_ff @(posedge clk) begin
      if (rst) cause_q[i] <= 1'b0;
      else     cause_q[i] <= cause_d[i];
    end
  end
endmodule

// File: rtl/irq_cause_group.sv
module irq_cause_group
  import icg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq_o
);
  icg_strobe_t strb;
  logic [W-1:0] mask_d, mask_q;
  logic [W-1:0] cause_d, cause_q, mode_q;
  logic [W-1:0] rd_mux;

  icg_decode u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .strb  (strb)
  );

  icg_mask_reg #(.W(W)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_wr (strb.mset_wr),
    .clr_wr (strb.mclr_wr),
    .wdata  (wdata),
    .mask_d (mask_d),
    .mask_q (mask_q)
  );

  icg_cause_reg #(.W(W)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_i),
    .rd_hit  (strb.cause_rd),
    .wr_hit  (strb.cause_wr),
    .mode_wr (strb.mode_wr),
    .wdata   (wdata),
    .cause_d (cause_d),
    .cause_q (cause_q),
    .mode_q  (mode_q)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_en) begin
      case (addr)
        A_CAUSE:   rd_mux = cause_q;
        A_PENDING: rd_mux = cause_q & ~mask_q;
        A_MASK:    rd_mux = mask_q;
        A_MODE:    rd_mux = mode_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      rdata <= rd_mux;
      irq_o <= |(cause_d & ~mask_d);
    end
  end
endmodule

// File: rtl/irq_cause_group_chk.sv
module irq_cause_group_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] evt_i,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic         irq_o,
  input logic [W-1:0] cause,
  input logic [W-1:0] mask,
  input logic [W-1:0] mode
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((cause & $past(evt_i)) == $past(evt_i)));

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2) |=> ((mask & $past(wdata)) == $past(wdata)));

  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3) |=> ((mask & $past(wdata)) == '0));

  assert_mask_ro_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4) |=> $stable(mask));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd0) |=> ((cause & $past(cause & mode & ~evt_i)) == '0));

  assert_view_no_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1 && !wr_en) |=> ((cause & $past(cause)) == $past(cause)));

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(cause & ~mask));

  assert_cause_rdata_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd0) |=> (rdata == $past(cause)));
endmodule

bind irq_cause_group irq_cause_group_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt_i (evt_i),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .irq_o (irq_o),
  .cause (cause_q),
  .mask  (mask_q),
  .mode  (mode_q)
);

// File: tb/sim_irq_cause_group.sv
module sim_irq_cause_group;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] evt_i = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq_o;

  int checks = 0;
  int failures = 0;

  irq_cause_group #(.W(W)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [W-1:0] m_cause, m_mask, m_mode, m_rdata;
  logic m_irq;
  always @(posedge clk) begin
    logic [W-1:0] clr, rv;
    if (rst) begin
      m_cause = '0; m_mask = '1; m_mode = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      rv = '0;
      if (rd_en) begin
        if (addr == 0) rv = m_cause;
        else if (addr == 1) rv = m_cause & ~m_mask;
        else if (addr == 4) rv = m_mask;
        else if (addr == 5) rv = m_mode;
      end
      clr = '0;
      if (rd_en && addr == 0) clr = clr | (m_cause & m_mode);
      if (wr_en && addr == 0) clr = clr | (wdata & ~m_mode);
      m_cause = (m_cause & ~clr) | evt_i;
      if (wr_en && addr == 2) m_mask = m_mask | wdata;
      if (wr_en && addr == 3) m_mask = m_mask & ~wdata;
      if (wr_en && addr == 5) m_mode = wdata;
      m_rdata = rv;
      m_irq = |(m_cause & ~m_mask);
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R12 rdata vs model", rdata, m_rdata);
      check("R11 irq vs model", {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
    end
  end

  task automatic cyc(input logic we, input logic re, input logic [2:0] a,
                     input logic [W-1:0] wd, input logic [W-1:0] ev);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = wd; evt_i = ev;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    cyc(1'b0, 1'b1, a, '0, '0);
    v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(1'b1, 1'b0, a, d, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(3'd4, v); check("R1 mask all ones", v, '1);
    rd(3'd0, v); check("R1 cause zero", v, '0);
    rd(3'd5, v); check("R1 mode zero", v, '0);
    // R2 sticky event, masked irq
    cyc(1'b0, 1'b0, 3'd0, '0, 32'h8);
    rd(3'd0, v); check("R2 event sets bit", v, 32'h8);
    rd(3'd0, v); check("R8 W1C bit survives read", v, 32'h8);
    check("R11 masked no irq", {31'b0, irq_o}, 32'h0);
    // R4 unmask
    wr(3'd3, 32'h8);
    check("R4/R11 irq after unmask", {31'b0, irq_o}, 32'h1);
    rd(3'd4, v); check("R4 mask after clear", v, ~32'h8);
    rd(3'd1, v); check("R9 pending view", v, 32'h8);
    rd(3'd0, v); check("R9 view did not clear", v, 32'h8);
    // R3 re-mask
    wr(3'd2, 32'h8);
    check("R3 irq off after mask", {31'b0, irq_o}, 32'h0);
    rd(3'd4, v); check("R3 mask all ones", v, '1);
    // R5 read-only mask
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R5 mask write ignored", v, '1);
    wr(3'd3, 32'hFFFF_FFFF);
    check("R4 all unmasked irq", {31'b0, irq_o}, 32'h1);
    // R7 write one clears
    wr(3'd0, 32'h8);
    check("R7 irq off after clear", {31'b0, irq_o}, 32'h0);
    rd(3'd0, v); check("R7 cause cleared", v, 32'h0);
    // R6 clear mode
    wr(3'd5, 32'h0000_00F0);
    rd(3'd5, v); check("R6 mode readback", v, 32'h0000_00F0);
    // R8 read clears, mixed with W1C bit
    cyc(1'b0, 1'b0, 3'd0, '0, 32'h0000_0131);
    rd(3'd0, v); check("R8 read returns causes", v, 32'h0000_0131);
    rd(3'd0, v); check("R8 COR bits cleared", v, 32'h0000_0101);
    // R7 write ignored on COR bit
    cyc(1'b0, 1'b0, 3'd0, '0, 32'h10);
    wr(3'd0, 32'h0000_0111);
    rd(3'd0, v); check("R7 COR bit ignores write", v, 32'h10);
    rd(3'd0, v); check("R8 COR cleared by read", v, 32'h0);
    // R10 event wins over write clear
    cyc(1'b0, 1'b0, 3'd0, '0, 32'h4);
    cyc(1'b1, 1'b0, 3'd0, 32'h4, 32'h4);
    rd(3'd0, v); check("R10 event beats write clear", v, 32'h4);
    wr(3'd0, 32'h4);
    // R10 event wins over read clear
    cyc(1'b0, 1'b0, 3'd0, '0, 32'h20);
    cyc(1'b0, 1'b1, 3'd0, '0, 32'h20);
    check("R10 read data during collision", rdata, 32'h20);
    rd(3'd0, v); check("R10 event beats read clear", v, 32'h20);
    // R12 unmapped and write-only reads
    rd(3'd7, v); check("R12 unmapped reads zero", v, 32'h0);
    rd(3'd2, v); check("R12 mask-set reads zero", v, 32'h0);
    @(negedge clk);
    check("R12 idle rdata zero", rdata, 32'h0);
    // mixed random traffic vs model
    for (int k = 0; k < 400; k++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom_range(0, 7)),
          $urandom, $urandom & $urandom & $urandom);
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule